// File: doc/BRIEF.md
# Trap and Trace Entry Controller

This block builds the processor context that an exception needs before the dispatch engine starts its memory traffic. It handles seven synchronous fault-style traps, the trace trap and the interrupt entry, including interrupts that arrive while a string instruction is only partly done. The caller presents one request with an exception kind and the machine state. One cycle later the block returns a dispatch vector, a return address, the status word to be pushed, the status word that stays in force and the stack pointer to use.

The status register is 16 bits wide. Trace enable sits at bit 1, user mode at bit 8, stack select at bit 9, pending trace at bit 10 and interrupt enable at bit 11. A fault-style trap first rolls the status and stack pointer back to their values at the start of the trapped instruction. Trace and interrupt entries work from the current values instead. The block keeps its outputs after a result, so the dispatch engine can read them for as long as it needs.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, `res_vld` is 0 after that edge and every result output is 0.
- R2: A request (`req_vld`=1 with a kind code 0..8) makes `res_vld` 1 in the next cycle only. A cycle with no accepted request makes `res_vld` 0 in the next cycle.
- R3: Kind codes give these vectors: 0 slave 3, 1 illegal 4, 2 supervisor call 5, 3 divide by zero 6, 4 flag 7, 5 breakpoint 8, 6 undefined 10, 7 trace 9. Code 8 (interrupt) gives vector 0, because the acknowledge logic supplies the real vector.
- R4: For kinds 0..6 the result works from `psr_orig` and `sp_orig`. `sp_out` equals `sp_orig`.
- R5: For kind 6 only, bit 10 is cleared in `psr_copy`. For kinds 0..5, `psr_copy` equals `psr_orig` exactly.
- R6: For kinds 0..6, `psr_new` equals `psr_copy` with bits 1, 8, 9 and 10 cleared. `ret_addr` equals `pc_cur`.
- R7: For kind 7, `psr_copy` is `psr_cur` with bit 10 cleared. `psr_new` additionally clears bits 1, 8 and 9. `ret_addr` equals `pc_next`.
- R8: For kind 8 with `str_pend`=0, `psr_copy` equals `psr_cur`. `psr_new` clears bits 1, 8, 9, 10 and 11. `ret_addr` equals `pc_next`.
- R9: For kind 8 with `str_pend`=1, bit 10 is cleared in `psr_copy` and `ret_addr` equals `pc_cur`.
- R10: Kinds 7 and 8 leave the stack pointer as it is: `sp_out` equals `sp_cur`. `str_pend` has no effect on kinds other than 8.
- R11: Kind codes 9..15 are ignored. `res_vld` stays 0 and all result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Entry request strobe |
| req_kind | input | 4 | Exception kind code (0..8 valid) |
| str_pend | input | 1 | Interrupted string instruction is unfinished |
| psr_cur | input | 16 | Current status register |
| psr_orig | input | 16 | Status at start of current instruction |
| sp_cur | input | 32 | Current selected stack pointer |
| sp_orig | input | 32 | Stack pointer at start of current instruction |
| pc_cur | input | 32 | Address of first byte of current instruction |
| pc_next | input | 32 | Address of next instruction |
| res_vld | output | 1 | Result valid, one cycle after request |
| vec_out | output | 8 | Dispatch vector |
| ret_addr | output | 32 | Return address |
| psr_copy | output | 16 | Status value to save |
| psr_new | output | 16 | Status value in force after entry |
| sp_out | output | 32 | Stack pointer after entry |

## Verification
Each result passes through one register, so every output for a request driven in one cycle is due one clock edge later, together with `res_vld`. The driver applies a request just after a falling edge and queues the expected result. The monitor checks the outputs at the next falling edge whenever `res_vld` is high, so it samples half a cycle after the registers update. For ignored codes, the driver checks at that same falling edge that `res_vld` is low and that the outputs still show the previous result.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int KIND_W = 4;

  // Status bit positions
  localparam int BIT_T = 1;
  localparam int BIT_U = 8;
  localparam int BIT_S = 9;
  localparam int BIT_P = 10;
  localparam int BIT_I = 11;

  typedef enum logic [KIND_W-1:0] {
    EK_SLAVE   = 4'd0,
    EK_ILLEGAL = 4'd1,
    EK_SVC     = 4'd2,
    EK_DVZ     = 4'd3,
    EK_FLAG    = 4'd4,
    EK_BPT     = 4'd5,
    EK_UNDEF   = 4'd6,
    EK_TRACE   = 4'd7,
    EK_INTR    = 4'd8
  } exc_kind_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_FAULT = 2'd1,
    CLS_TRACE = 2'd2,
    CLS_INTR  = 2'd3
  } exc_cls_e;
endpackage

// File: rtl/trap_kind_decode.sv
module trap_kind_decode
  import trap_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [KIND_W-1:0] kind,
  output exc_cls_e          cls,
  output logic [VEC_W-1:0]  vec,
  output logic              is_undef
);
  always_comb begin
    cls      = CLS_FAULT;
    vec      = '0;
    is_undef = 1'b0;
    case (kind)
      EK_SLAVE:   vec = VEC_W'(3);
      EK_ILLEGAL: vec = VEC_W'(4);
      EK_SVC:     vec = VEC_W'(5);
      EK_DVZ:     vec = VEC_W'(6);
      EK_FLAG:    vec = VEC_W'(7);
      EK_BPT:     vec = VEC_W'(8);
      EK_UNDEF: begin
        vec      = VEC_W'(10);
        is_undef = 1'b1;
      end
      EK_TRACE: begin
        vec = VEC_W'(9);
        cls = CLS_TRACE;
      end
      EK_INTR: cls = CLS_INTR;
      default: cls = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/trap_status_mask.sv
module trap_status_mask
  import trap_entry_pkg::*;
#(
  parameter int PSR_W = 16
) (
  input  exc_cls_e          cls,
  input  logic              is_undef,
  input  logic              str_pend,
  input  logic [PSR_W-1:0]  psr_cur,
  input  logic [PSR_W-1:0]  psr_orig,
  output logic [PSR_W-1:0]  copy_val,
  output logic [PSR_W-1:0]  new_val
);
  localparam logic [PSR_W-1:0] ONE   = {{(PSR_W-1){1'b0}}, 1'b1};
  localparam logic [PSR_W-1:0] M_T   = ONE << BIT_T;
  localparam logic [PSR_W-1:0] M_U   = ONE << BIT_U;
  localparam logic [PSR_W-1:0] M_S   = ONE << BIT_S;
  localparam logic [PSR_W-1:0] M_P   = ONE << BIT_P;
  localparam logic [PSR_W-1:0] M_I   = ONE << BIT_I;
  localparam logic [PSR_W-1:0] CLR_FAULT = M_T | M_U | M_S | M_P;
  localparam logic [PSR_W-1:0] CLR_TRACE = M_T | M_U | M_S;
  localparam logic [PSR_W-1:0] CLR_INTR  = M_T | M_U | M_S | M_P | M_I;

  logic [PSR_W-1:0] base;
  logic [PSR_W-1:0] pre_clr;
  logic [PSR_W-1:0] post_clr;

  always_comb begin
    base     = psr_cur;
    pre_clr  = '0;
    post_clr = '0;
    unique case (cls)
      CLS_FAULT: begin
        base     = psr_orig;
        pre_clr  = is_undef ? M_P : '0;
        post_clr = CLR_FAULT;
      end
      CLS_TRACE: begin
        pre_clr  = M_P;
        post_clr = CLR_TRACE;
      end
      CLS_INTR: begin
        pre_clr  = str_pend ? M_P : '0;
        post_clr = CLR_INTR;
      end
      default: ;
    endcase
    copy_val = base & ~pre_clr;
    new_val  = copy_val & ~post_clr;
  end
endmodule

// File: rtl/trap_ctx_select.sv
module trap_ctx_select
  import trap_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SP_W   = 32
) (
  input  exc_cls_e           cls,
  input  logic               str_pend,
  input  logic [ADDR_W-1:0]  pc_cur,
  input  logic [ADDR_W-1:0]  pc_next,
  input  logic [SP_W-1:0]    sp_cur,
  input  logic [SP_W-1:0]    sp_orig,
  output logic [ADDR_W-1:0]  ret_val,
  output logic [SP_W-1:0]    sp_val
);
  always_comb begin
    ret_val = pc_next;
    sp_val  = sp_cur;
    if (cls == CLS_FAULT) begin
      ret_val = pc_cur;
      sp_val  = sp_orig;
    end else if (cls == CLS_INTR && str_pend) begin
      ret_val = pc_cur;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int PSR_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SP_W   = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              str_pend,
  input  logic [PSR_W-1:0]  psr_cur,
  input  logic [PSR_W-1:0]  psr_orig,
  input  logic [SP_W-1:0]   sp_cur,
  input  logic [SP_W-1:0]   sp_orig,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] pc_next,
  output logic              res_vld,
  output logic [VEC_W-1:0]  vec_out,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [PSR_W-1:0]  psr_copy,
  output logic [PSR_W-1:0]  psr_new,
  output logic [SP_W-1:0]   sp_out
);
  exc_cls_e          cls;
  logic              is_undef;
  logic [VEC_W-1:0]  vec_d;
  logic [PSR_W-1:0]  copy_d;
  logic [PSR_W-1:0]  new_d;
  logic [ADDR_W-1:0] ret_d;
  logic [SP_W-1:0]   sp_d;
  logic              accept;

  trap_kind_decode #(.VEC_W(VEC_W)) u_dec (
    .kind     (req_kind),
    .cls      (cls),
    .vec      (vec_d),
    .is_undef (is_undef)
  );

  trap_status_mask #(.PSR_W(PSR_W)) u_psr (
    .cls      (cls),
    .is_undef (is_undef),
    .str_pend (str_pend),
    .psr_cur  (psr_cur),
    .psr_orig (psr_orig),
    .copy_val (copy_d),
    .new_val  (new_d)
  );

  trap_ctx_select #(.ADDR_W(ADDR_W), .SP_W(SP_W)) u_ctx (
    .cls      (cls),
    .str_pend (str_pend),
    .pc_cur   (pc_cur),
    .pc_next  (pc_next),
    .sp_cur   (sp_cur),
    .sp_orig  (sp_orig),
    .ret_val  (ret_d),
    .sp_val   (sp_d)
  );

  assign accept = req_vld && (cls != CLS_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      vec_out  <= '0;
      ret_addr <= '0;
      psr_copy <= '0;
      psr_new  <= '0;
      sp_out   <= '0;
    end else begin
      res_vld <= accept;
      if (accept) begin
        vec_out  <= vec_d;
        ret_addr <= ret_d;
        psr_copy <= copy_d;
        psr_new  <= new_d;
        sp_out   <= sp_d;
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_entry_pkg::*;
#(
  parameter int PSR_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SP_W   = 32,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_vld,
  input logic [KIND_W-1:0] req_kind,
  input logic              str_pend,
  input logic [PSR_W-1:0]  psr_cur,
  input logic [PSR_W-1:0]  psr_orig,
  input logic [SP_W-1:0]   sp_cur,
  input logic [SP_W-1:0]   sp_orig,
  input logic [ADDR_W-1:0] pc_cur,
  input logic [ADDR_W-1:0] pc_next,
  input logic              res_vld,
  input logic [VEC_W-1:0]  vec_out,
  input logic [ADDR_W-1:0] ret_addr,
  input logic [PSR_W-1:0]  psr_copy,
  input logic [PSR_W-1:0]  psr_new,
  input logic [SP_W-1:0]   sp_out
);
  localparam logic [PSR_W-1:0] ONE = {{(PSR_W-1){1'b0}}, 1'b1};
  localparam logic [PSR_W-1:0] F_MASK = (ONE << BIT_T) | (ONE << BIT_U) |
                                        (ONE << BIT_S) | (ONE << BIT_P);
  localparam logic [PSR_W-1:0] I_MASK = F_MASK | (ONE << BIT_I);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !res_vld);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_kind <= KIND_W'(8)) |=> res_vld);

  assert_ignore_R11: assert property (@(posedge clk) disable iff (rst)
    !(req_vld && req_kind <= KIND_W'(8)) |=> !res_vld);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> ($stable(ret_addr) && $stable(psr_new) && $stable(sp_out)));

  assert_fault_ctx_R6: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(req_kind) <= KIND_W'(6)) |->
      ((psr_new & F_MASK) == '0 && ret_addr == $past(pc_cur) && sp_out == $past(sp_orig)));

  assert_trace_vec_R7: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(req_kind) == KIND_W'(7)) |->
      (vec_out == VEC_W'(9) && (psr_new & F_MASK) == '0 && ret_addr == $past(pc_next)));

  assert_intr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(req_kind) == KIND_W'(8)) |->
      ((psr_new & I_MASK) == '0 && sp_out == $past(sp_cur)));
endmodule

bind trap_entry_ctrl trap_entry_chk #(
  .PSR_W(PSR_W), .ADDR_W(ADDR_W), .SP_W(SP_W), .VEC_W(VEC_W)
) u_chk (.*);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic [3:0]  req_kind = '0;
  logic        str_pend = 1'b0;
  logic [15:0] psr_cur = '0, psr_orig = '0;
  logic [31:0] sp_cur = '0, sp_orig = '0, pc_cur = '0, pc_next = '0;
  logic        res_vld;
  logic [7:0]  vec_out;
  logic [31:0] ret_addr;
  logic [15:0] psr_copy, psr_new;
  logic [31:0] sp_out;

  typedef struct packed {
    logic [7:0]  vec;
    logic [31:0] ret;
    logic [15:0] copy;
    logic [15:0] nw;
    logic [31:0] sp;
  } exp_t;

  exp_t sb[$];
  exp_t last_exp;
  int   n_cmp = 0;
  int   n_bad = 0;

  localparam logic [15:0] B_T = 16'h0002, B_U = 16'h0100, B_S = 16'h0200,
                          B_P = 16'h0400, B_I = 16'h0800;

  always #10 clk = ~clk;

  trap_entry_ctrl u_dut (.*);

  function automatic exp_t model(input logic [3:0] k, input logic sp_,
      input logic [15:0] pc_s, input logic [15:0] po_s,
      input logic [31:0] sc, input logic [31:0] so,
      input logic [31:0] a0, input logic [31:0] a1);
    exp_t e;
    logic [7:0] vt[7] = '{8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd10};
    if (k <= 4'd6) begin                                   // R3 R4 R5 R6
      e.vec  = vt[k];
      e.copy = (k == 4'd6) ? (po_s & ~B_P) : po_s;
      e.nw   = e.copy & ~(B_T | B_U | B_S | B_P);
      e.ret  = a0;
      e.sp   = so;
    end else if (k == 4'd7) begin                          // R7 R10
      e.vec  = 8'd9;
      e.copy = pc_s & ~B_P;
      e.nw   = e.copy & ~(B_T | B_U | B_S);
      e.ret  = a1;
      e.sp   = sc;
    end else begin                                         // R8 R9 R10
      e.vec  = 8'd0;
      e.copy = sp_ ? (pc_s & ~B_P) : pc_s;
      e.nw   = e.copy & ~(B_T | B_U | B_S | B_P | B_I);
      e.ret  = sp_ ? a0 : a1;
      e.sp   = sc;
    end
    return e;
  endfunction

  task automatic send(input logic [3:0] k, input logic sp_,
      input logic [15:0] pcs, input logic [15:0] pos,
      input logic [31:0] sc, input logic [31:0] so,
      input logic [31:0] a0, input logic [31:0] a1);
    req_vld = 1'b1; req_kind = k; str_pend = sp_;
    psr_cur = pcs; psr_orig = pos; sp_cur = sc; sp_orig = so;
    pc_cur = a0; pc_next = a1;
    if (k <= 4'd8) begin
      last_exp = model(k, sp_, pcs, pos, sc, so, a0, a1);
      sb.push_back(last_exp);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    req_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_ignored(input logic [3:0] k);
    send(k, 1'b1, 16'hFFFF, 16'hFFFF, 32'hDEAD0000, 32'hBEEF0000, 32'h11112222, 32'h33334444);
    n_cmp++;
    if (res_vld !== 1'b0 || {vec_out, ret_addr, psr_copy, psr_new, sp_out} !== last_exp) begin
      n_bad++;
      $display("FAIL R11 kind %0d: vld=%b out=%h expected vld=0 out=%h", k, res_vld,
               {vec_out, ret_addr, psr_copy, psr_new, sp_out}, last_exp);
    end
  endtask

  // Monitor: compare each valid result with the queue head
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      exp_t got;
      got = '{vec_out, ret_addr, psr_copy, psr_new, sp_out};
      n_cmp++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected result %h expected none", got);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (got !== e) begin
          n_bad++;
          $display("FAIL R3-R10 result: got vec=%0d ret=%h copy=%h new=%h sp=%h expected vec=%0d ret=%h copy=%h new=%h sp=%h",
                   got.vec, got.ret, got.copy, got.nw, got.sp, e.vec, e.ret, e.copy, e.nw, e.sp);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    last_exp = '0;
    repeat (3) @(negedge clk);
    n_cmp++;                                                // R1 reset state
    if (res_vld !== 1'b0 || {vec_out, ret_addr, psr_copy, psr_new, sp_out} !== '0) begin
      n_bad++;
      $display("FAIL R1: vld=%b out=%h expected all zero", res_vld,
               {vec_out, ret_addr, psr_copy, psr_new, sp_out});
    end
    rst = 1'b0;
    @(negedge clk);

    // R3 R4 R5 R6: each fault kind, back to back
    for (int k = 0; k <= 6; k++)
      send(4'(k), 1'b1, 16'h0F0F, 16'hFF03 ^ 16'(k), 32'h1000 + k, 32'h2000 + k,
           32'h4000 + 4 * k, 32'h4002 + 4 * k);
    idle();
    // R5: undefined with P set versus breakpoint with P set
    send(4'd6, 1'b0, 16'h0000, 16'h0E03, 32'hA, 32'hB, 32'h500, 32'h504);
    send(4'd5, 1'b0, 16'h0000, 16'h0E03, 32'hA, 32'hB, 32'h600, 32'h604);
    idle();
    // R7: trace with P set and with all bits set
    send(4'd7, 1'b1, 16'h0F03, 16'h0000, 32'hC0, 32'hD0, 32'h700, 32'h702);
    send(4'd7, 1'b0, 16'hFFFF, 16'h1234, 32'hC1, 32'hD1, 32'h800, 32'h803);
    idle();
    // R8 R9: interrupt without and with unfinished string
    send(4'd8, 1'b0, 16'hFFFF, 16'h0000, 32'hE0, 32'hF0, 32'h900, 32'h904);
    idle();
    send(4'd8, 1'b1, 16'h0F02, 16'h0000, 32'hE1, 32'hF1, 32'hA00, 32'hA06);
    send(4'd8, 1'b1, 16'hFFFF, 16'h0000, 32'hE2, 32'hF2, 32'hB00, 32'hB01);
    idle();
    // R11: unknown kinds ignored, outputs held
    check_ignored(4'd9);
    idle();
    check_ignored(4'd15);
    idle();
    // R10: stack pointer kept for trace and interrupt
    send(4'd7, 1'b1, 16'h0300, 16'hFFFF, 32'h7777, 32'h8888, 32'hC00, 32'hC04);
    send(4'd8, 1'b0, 16'h0300, 16'hFFFF, 32'h7778, 32'h8889, 32'hD00, 32'hD04);
    idle();
    idle();

    n_cmp++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d results missing, expected 0", sb.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule